// File: doc/BRIEF.md
# USB2 L1 Sleep Request Responder

This block sits on the device side of a USB 2.0 link and decides how to answer the host's request to put the link into the L1 sleep state. The host sends such a request only after the bus has been quiet for a while. The responder evaluates each decoded request in the cycle it arrives. It weighs the device's own pending work and the resume duration the host offers against a programmable tolerance. From that it produces one handshake: ACK, NYET or a refusal.

The host's resume duration arrives as a 4-bit code. The responder turns it into microseconds as 50 + 75 × code and compares the result with a limit that software programs. A typical limit is about 300 µs while a transfer stream is merely paused, and about 1025 µs when the connection is idle. Once the link is asleep, the responder tracks the L1 state. It leaves L1 either when the host drives resume or, if remote wake is enabled, by raising a wake request of fixed length when the device has new data. A bus reset returns the responder to the active state from anywhere.

Top module: `lpm_l1_responder`

## Requirements
- R1: While rstN is low, and on the first cycle after it, hsValid, inL1 and wakeReq are all 0.
- R2: A request taken in the active state yields exactly one cycle of hsValid, in the cycle after the request, and hsValid is never high otherwise. hsCode carries 1 for ACK, 2 for NYET and 3 for refusal.
- R3: If devBusy is high when a request is taken, the answer is NYET and the link stays active. Busy takes priority over the resume-duration check.
- R4: If the device is idle and 50 + 75 × l1Hird (µs) is strictly greater than hirdLimitUs, the answer is refusal (3) and the link stays active.
- R5: If the device is idle and the converted duration is at most hirdLimitUs (equality accepted), the answer is ACK and inL1 is high from the same cycle as hsValid.
- R6: While in L1 or while waking, a request produces no handshake and does not change the state.
- R7: In L1, hostResume returns the link to active (inL1 low) in the next cycle.
- R8: In L1, with devBusy and rwEnable both high, wakeReq is high for exactly RESUME_CYCLES consecutive cycles starting the next cycle. After that the link is active, and inL1 and wakeReq are never high together.
- R9: In L1 with rwEnable low, devBusy keeps the link in L1 and never raises wakeReq.
- R10: If hostResume arrives in the same cycle as a remote-wake condition, host resume wins: the link goes active and wakeReq stays low.
- R11: busReset forces the active state in the next cycle from any state, clears wakeReq and suppresses the handshake of a request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busReset | input | 1 | USB bus reset detected |
| l1ReqValid | input | 1 | One-cycle strobe: decoded L1 request token |
| l1Hird | input | 4 | Resume-duration code carried in the request |
| devBusy | input | 1 | Device has pending data or activity |
| rwEnable | input | 1 | Remote wake is permitted |
| hostResume | input | 1 | Host is driving resume on the bus |
| hirdLimitUs | input | 11 | Longest tolerated resume duration, microseconds |
| hsValid | output | 1 | Handshake strobe |
| hsCode | output | 2 | Handshake: 1 ACK, 2 NYET, 3 refusal |
| inL1 | output | 1 | Link is in L1 |
| wakeReq | output | 1 | Device is driving a remote-wake resume |

## Verification
Two pairs of events can land in the same cycle. In L1, a host resume can coincide with the device's own wake condition. In the active state, a bus reset can coincide with an incoming sleep request. The bench raises hostResume together with devBusy and rwEnable while asleep, and expects the link to go active with no wake pulse. It also asserts busReset in the same cycle as l1ReqValid and expects neither a handshake nor entry to L1. The boundary between acceptance and refusal is probed with a converted duration exactly equal to the limit and one step either side of it.

// File: rtl/lpm_l1_pkg.sv
package lpm_l1_pkg;

  typedef enum logic [1:0] {
    HS_NONE   = 2'd0,
    HS_ACK    = 2'd1,
    HS_NYET   = 2'd2,
    HS_REJECT = 2'd3
  } hs_code_e;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_SLEEP  = 2'd1,
    ST_WAKE   = 2'd2
  } link_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic startResume;
    logic runResume;
  } ctrl_strobe_t;

endpackage

// File: rtl/lpm_l1_datapath.sv
module lpm_l1_datapath
  import lpm_l1_pkg::*;
#(
  parameter int HIRD_W        = 4,
  parameter int BASE_US       = 50,
  parameter int STEP_US       = 75,
  parameter int US_W          = 11,
  parameter int RESUME_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic [HIRD_W-1:0] hirdCode,
  input  logic [US_W-1:0]   hirdLimitUs,
  output logic              hirdTooLong,
  output logic              resumeDone
);

  localparam int CNT_W = (RESUME_CYCLES > 1) ? $clog2(RESUME_CYCLES) : 1;

  logic [US_W-1:0]  hirdUs;
  logic [CNT_W-1:0] resumeCnt;

  // Resume duration in microseconds: base plus one step per code
  always_comb begin
    hirdUs      = US_W'(BASE_US + STEP_US * int'(hirdCode));
    hirdTooLong = hirdUs > hirdLimitUs;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resumeCnt <= '0;
    end else if (strobe.startResume) begin
      resumeCnt <= CNT_W'(RESUME_CYCLES - 1);
    end else if (strobe.runResume && resumeCnt != '0) begin
      resumeCnt <= resumeCnt - 1'b1;
    end
  end

  assign resumeDone = (resumeCnt == '0);

endmodule

// File: rtl/lpm_l1_ctrl.sv
module lpm_l1_ctrl
  import lpm_l1_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         busReset,
  input  logic         l1ReqValid,
  input  logic         devBusy,
  input  logic         rwEnable,
  input  logic         hostResume,
  input  logic         hirdTooLong,
  input  logic         resumeDone,
  output ctrl_strobe_t strobe,
  output logic         hsValid,
  output logic [1:0]   hsCode,
  output logic         inL1,
  output logic         wakeReq
);

  link_state_e state, stateNext;
  hs_code_e    hsNext;

  always_comb begin
    stateNext          = state;
    hsNext             = HS_NONE;
    strobe.startResume = 1'b0;
    strobe.runResume   = 1'b0;
    if (busReset) begin
      stateNext = ST_ACTIVE;
    end else begin
      unique case (state)
        ST_ACTIVE: begin
          if (l1ReqValid) begin
            if (devBusy) begin
              hsNext = HS_NYET;
            end else if (hirdTooLong) begin
              hsNext = HS_REJECT;
            end else begin
              hsNext    = HS_ACK;
              stateNext = ST_SLEEP;
            end
          end
        end
        ST_SLEEP: begin
          // host resume outranks a device-initiated exit
          if (hostResume) begin
            stateNext = ST_ACTIVE;
          end else if (devBusy && rwEnable) begin
            stateNext          = ST_WAKE;
            strobe.startResume = 1'b1;
          end
        end
        ST_WAKE: begin
          strobe.runResume = 1'b1;
          if (resumeDone) stateNext = ST_ACTIVE;
        end
        default: stateNext = ST_ACTIVE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_ACTIVE;
      hsValid <= 1'b0;
      hsCode  <= HS_NONE;
    end else begin
      state   <= stateNext;
      hsValid <= (hsNext != HS_NONE);
      hsCode  <= hsNext;
    end
  end

  assign inL1    = (state == ST_SLEEP);
  assign wakeReq = (state == ST_WAKE);

endmodule

// File: rtl/lpm_l1_responder.sv
module lpm_l1_responder
  import lpm_l1_pkg::*;
#(
  parameter int HIRD_W        = 4,
  parameter int BASE_US       = 50,
  parameter int STEP_US       = 75,
  parameter int RESUME_CYCLES = 16,
  parameter int US_W          = $clog2(BASE_US + STEP_US * ((1 << HIRD_W) - 1) + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReset,
  input  logic              l1ReqValid,
  input  logic [HIRD_W-1:0] l1Hird,
  input  logic              devBusy,
  input  logic              rwEnable,
  input  logic              hostResume,
  input  logic [US_W-1:0]   hirdLimitUs,
  output logic              hsValid,
  output logic [1:0]        hsCode,
  output logic              inL1,
  output logic              wakeReq
);

  ctrl_strobe_t strobe;
  logic         hirdTooLong;
  logic         resumeDone;

  lpm_l1_datapath #(
    .HIRD_W       (HIRD_W),
    .BASE_US      (BASE_US),
    .STEP_US      (STEP_US),
    .US_W         (US_W),
    .RESUME_CYCLES(RESUME_CYCLES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .hirdCode    (l1Hird),
    .hirdLimitUs (hirdLimitUs),
    .hirdTooLong (hirdTooLong),
    .resumeDone  (resumeDone)
  );

  lpm_l1_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .busReset    (busReset),
    .l1ReqValid  (l1ReqValid),
    .devBusy     (devBusy),
    .rwEnable    (rwEnable),
    .hostResume  (hostResume),
    .hirdTooLong (hirdTooLong),
    .resumeDone  (resumeDone),
    .strobe      (strobe),
    .hsValid     (hsValid),
    .hsCode      (hsCode),
    .inL1        (inL1),
    .wakeReq     (wakeReq)
  );

endmodule

// File: rtl/lpm_l1_checker.sv
module lpm_l1_checker (
  input logic       clk,
  input logic       rstN,
  input logic       busReset,
  input logic       l1ReqValid,
  input logic       devBusy,
  input logic       rwEnable,
  input logic       hostResume,
  input logic       hsValid,
  input logic [1:0] hsCode,
  input logic       inL1,
  input logic       wakeReq
);

  logic idleState;
  assign idleState = !inL1 && !wakeReq;

  AST_HS_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    hsValid |-> $past(l1ReqValid) && !$past(busReset)); // R2

  AST_BUSY_NYET: assert property (@(posedge clk) disable iff (!rstN)
    (l1ReqValid && !busReset && idleState && devBusy) |=> (hsValid && hsCode == 2'd2 && !inL1)); // R3

  AST_ACK_SLEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (hsValid && hsCode == 2'd1) |-> inL1); // R5

  AST_NO_HS_ASLEEP: assert property (@(posedge clk) disable iff (!rstN)
    (inL1 && l1ReqValid) |=> !hsValid); // R6

  AST_HOST_RESUME: assert property (@(posedge clk) disable iff (!rstN)
    (inL1 && hostResume && !busReset) |=> (!inL1 && !wakeReq)); // R10

  AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (inL1 && !rwEnable && !hostResume && !busReset) |=> inL1); // R9

  AST_STATE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(inL1 && wakeReq)); // R8

  AST_BUS_RESET: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> (!inL1 && !wakeReq && !hsValid)); // R11

endmodule

bind lpm_l1_responder lpm_l1_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busReset   (busReset),
  .l1ReqValid (l1ReqValid),
  .devBusy    (devBusy),
  .rwEnable   (rwEnable),
  .hostResume (hostResume),
  .hsValid    (hsValid),
  .hsCode     (hsCode),
  .inL1       (inL1),
  .wakeReq    (wakeReq)
);

// File: tb/sim_lpm_l1_responder.sv
module sim_lpm_l1_responder;

  localparam int RC = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busReset = 1'b0;
  logic        l1ReqValid = 1'b0;
  logic [3:0]  l1Hird = '0;
  logic        devBusy = 1'b0;
  logic        rwEnable = 1'b0;
  logic        hostResume = 1'b0;
  logic [10:0] hirdLimitUs = 11'd300;
  logic        hsValid;
  logic [1:0]  hsCode;
  logic        inL1;
  logic        wakeReq;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #10 clk = ~clk;  // 50 MHz

  lpm_l1_responder #(.RESUME_CYCLES(RC)) u0 (
    .clk(clk), .rstN(rstN), .busReset(busReset), .l1ReqValid(l1ReqValid),
    .l1Hird(l1Hird), .devBusy(devBusy), .rwEnable(rwEnable),
    .hostResume(hostResume), .hirdLimitUs(hirdLimitUs),
    .hsValid(hsValid), .hsCode(hsCode), .inL1(inL1), .wakeReq(wakeReq)
  );

  // {expected code, busy, hird code, limit}
  localparam int NV = 10;
  localparam logic [17:0] VEC [NV] = '{
    {2'd1, 1'b0, 4'd3,  11'd300},   // 275 us <= 300 -> ACK
    {2'd2, 1'b1, 4'd0,  11'd300},   // busy -> NYET
    {2'd3, 1'b0, 4'd4,  11'd300},   // 350 us > 300 -> refuse
    {2'd1, 1'b0, 4'd13, 11'd1025},  // 1025 == 1025 -> ACK
    {2'd3, 1'b0, 4'd14, 11'd1025},  // 1100 -> refuse
    {2'd2, 1'b1, 4'd15, 11'd1025},  // busy outranks refusal
    {2'd1, 1'b0, 4'd0,  11'd50},    // 50 == 50 -> ACK
    {2'd3, 1'b0, 4'd0,  11'd49},    // 50 > 49 -> refuse
    {2'd1, 1'b0, 4'd15, 11'd2047},  // 1175 -> ACK
    {2'd2, 1'b1, 4'd3,  11'd300}    // busy -> NYET
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic enterSleep();
    devBusy = 1'b0; hirdLimitUs = 11'd300; l1Hird = 4'd1; l1ReqValid = 1'b1;
    step();
    l1ReqValid = 1'b0;
    chk("R5 enter L1", int'(inL1), 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nFails++;
      $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    step(); step();
    chk("R1 reset hsValid", int'(hsValid), 0);
    chk("R1 reset inL1", int'(inL1), 0);
    chk("R1 reset wakeReq", int'(wakeReq), 0);
    rstN = 1'b1;
    step();
    chk("R1 after reset hsValid", int'(hsValid), 0);
    chk("R1 after reset inL1", int'(inL1), 0);

    // Vector table: decision per request
    for (int i = 0; i < NV; i++) begin
      logic [1:0] exp;
      string tag;
      exp         = VEC[i][17:16];
      devBusy     = VEC[i][15];
      l1Hird      = VEC[i][14:11];
      hirdLimitUs = VEC[i][10:0];
      tag = (exp == 2'd2) ? "R3" : (exp == 2'd3) ? "R4" : "R5";
      l1ReqValid = 1'b1;
      step();
      l1ReqValid = 1'b0;
      devBusy    = 1'b0;
      chk("R2 handshake strobe", int'(hsValid), 1);
      chk(tag, int'(hsCode), int'(exp));
      chk(tag, int'(inL1), (exp == 2'd1) ? 1 : 0);
      step();
      chk("R2 single-cycle strobe", int'(hsValid), 0);
      if (inL1) begin
        hostResume = 1'b1;
        step();
        hostResume = 1'b0;
        chk("R7 host resume exits L1", int'(inL1), 0);
      end
    end

    // R6: requests ignored while asleep
    enterSleep();
    step();
    l1ReqValid = 1'b1; devBusy = 1'b1;
    step();
    l1ReqValid = 1'b0;
    chk("R6 no handshake in L1", int'(hsValid), 0);
    chk("R6 still in L1", int'(inL1), 1);

    // R9: busy without remote-wake permission stays asleep
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R9 no wake when disabled", int'(wakeReq), 0);
      chk("R9 stays in L1", int'(inL1), 1);
    end

    // R8: remote wake pulse length
    rwEnable = 1'b1;
    step();
    devBusy = 1'b0;
    begin
      int high = 0;
      for (int k = 0; k < 100 && wakeReq; k++) begin
        high++;
        if (inL1) chk("R8 exclusive states", 1, 0);
        step();
      end
      chk("R8 wake length", high, RC);
    end
    chk("R8 active after wake", int'(inL1), 0);
    l1ReqValid = 1'b1; l1Hird = 4'd0; hirdLimitUs = 11'd300;
    step();
    l1ReqValid = 1'b0;
    chk("R8 answers again after wake", int'(hsCode), 1);

    // R10: host resume and device wake in the same cycle
    hostResume = 1'b1; devBusy = 1'b1;
    step();
    hostResume = 1'b0;
    chk("R10 host resume wins inL1", int'(inL1), 0);
    chk("R10 no wake pulse", int'(wakeReq), 0);
    step();
    chk("R10 no late wake", int'(wakeReq), 0);
    devBusy = 1'b0; rwEnable = 1'b0;

    // R11: bus reset from L1, during wake, and with a request
    enterSleep();
    busReset = 1'b1;
    step();
    busReset = 1'b0;
    chk("R11 reset leaves L1", int'(inL1), 0);
    enterSleep();
    rwEnable = 1'b1; devBusy = 1'b1;
    step();
    devBusy = 1'b0;
    chk("R8 wake started", int'(wakeReq), 1);
    busReset = 1'b1;
    step();
    busReset = 1'b0; rwEnable = 1'b0;
    chk("R11 reset ends wake", int'(wakeReq), 0);
    busReset = 1'b1; l1ReqValid = 1'b1; l1Hird = 4'd0;
    step();
    busReset = 1'b0; l1ReqValid = 1'b0;
    chk("R11 handshake suppressed", int'(hsValid), 0);
    chk("R11 no L1 entry", int'(inL1), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule